// File: doc/BRIEF.md
# Time-Slot Virtual-Channel Link Scheduler

This block sits on one output port of a mesh router and decides, cycle by cycle, which of several virtual channels may place a flit on the shared physical link. A table of local time slots repeats with a fixed period. A slot may be owned by one virtual channel, which gives that channel a guaranteed share of the link equal to the number of slots it owns (its service level). In a slot whose owner has a flit waiting and downstream credit, the owner sends. In every other case the link goes to the unreserved channels, which take turns by round robin.

A small configuration port reserves or releases slots. A reservation names a channel and a service level. It takes the lowest-numbered free slots, or it is refused whole when too few are free. A release frees every slot a channel owns. Each channel has a downstream credit counter that starts at the depth of the receiving buffer. Sending a flit spends one credit and a returned-credit pulse restores one. No flit goes out on a channel with no credit. The upstream input buffers see a one-hot pop strobe in the cycle of the grant. The flit, its channel number and a valid flag appear on the link one cycle later.

Top module: `tslot_link_sched`

## Requirements
- R1: After reset the link is idle, both configuration replies are low, no slot is owned, and every channel holds CREDIT_DEPTH (default 4) credits, so it can send that many flits with no credit returned.
- R2: At most one bit of `vc_pop` is set in any cycle, and bit v is set only while `vc_flit_valid[v]` is high. A pop of channel v in one cycle makes `link_valid` high in the next cycle, with `link_vc` equal to v in binary and `link_data` equal to the flit that was offered on channel v. Without a pop, `link_valid` is low in the next cycle.
- R3: A channel is popped only while its credit count is above zero. A pop lowers the count by one. A `credit_return[v]` pulse raises it by one. A pop and a return in the same cycle leave it unchanged.
- R4: When the current slot is owned by a channel that has a flit and credit, that channel is popped.
- R5: A channel that owns at least one slot is popped only in slots it owns. It takes no part in round-robin sharing.
- R6: In a slot with no owner, or whose owner has no flit or no credit, the eligible unreserved channels are served in round robin. The search starts at a pointer and goes upward in index with wrap-around. After each round-robin grant the pointer moves to the index one past the winner. The pointer starts at 0 after reset.
- R7: A reserve request with service level L, where 1 ≤ L ≤ the number of free slots, gives the channel the L lowest-numbered free slots (slots are numbered 0 to SLOTS-1). `cfg_done` pulses for one cycle, one cycle after the request.
- R8: A reserve request with L = 0, or with L larger than the number of free slots, pulses `cfg_error` for one cycle, one cycle after the request, and leaves every slot unchanged.
- R9: A release request frees, in that single cycle, every slot owned by the named channel and pulses `cfg_done` one cycle later. If release and reserve are requested together, the release is performed and the reserve is dropped.
- R10: The current slot is 0 in the first cycle after reset. It advances by one every cycle and wraps from SLOTS-1 (default 7) to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vc_flit_valid | input | NUM_VC | Per channel: a flit is waiting upstream |
| vc_flit_data | input | NUM_VC*FLIT_W | Head flit of each channel, channel v at bits v*FLIT_W upward |
| vc_pop | output | NUM_VC | One-hot dequeue strobe to the upstream buffer of the granted channel |
| credit_return | input | NUM_VC | Per channel: one downstream buffer entry was freed |
| cfg_reserve | input | 1 | Reserve request strobe |
| cfg_release | input | 1 | Release request strobe |
| cfg_vc | input | VC_W | Channel named by the request |
| cfg_level | input | SL_W | Service level (slot count) for a reserve |
| cfg_done | output | 1 | Request carried out |
| cfg_error | output | 1 | Reserve refused |
| link_valid | output | 1 | A flit is on the link |
| link_vc | output | VC_W | Binary channel number of the flit on the link |
| link_data | output | FLIT_W | Flit payload on the link |

## Verification
A corrupted slot owner or slot counter would at once move a reserved channel's flits into slots it does not own, or starve it in slots it does. The reference model flags this on the link within one slot period. A wrong credit count shows up either as a pop while the channel should be stalled or as a missing pop. Both appear at `vc_pop` in that same cycle and at `link_valid` one cycle later. A drifting round-robin pointer changes the order of `link_vc` on the next contested cycle. Faults in the free-slot search show up as a wrong done/error reply in the cycle after the request, or as slot ownership that turns up on the link later.

// File: rtl/tsls_pkg.sv
package tsls_pkg;

    // configuration operation decoded from the request strobes
    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_RESERVE = 2'd1,
        OP_RELEASE = 2'd2
    } cfg_op_e;

    // reply pair returned one cycle after a request
    typedef struct packed {
        logic done;
        logic err;
    } cfg_reply_t;

endpackage

// File: rtl/tsls_slot_table.sv
module tsls_slot_table
    import tsls_pkg::*;
#(
    parameter int NUM_VC = 4,
    parameter int SLOTS  = 8,
    parameter int VC_W   = 2,
    parameter int SL_W   = 4,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_reserve,
    input  logic              cfg_release,
    input  logic [VC_W-1:0]   cfg_vc,
    input  logic [SL_W-1:0]   cfg_level,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              owner_valid,
    output logic [VC_W-1:0]   owner_vc,
    output logic [NUM_VC-1:0] bound_mask,
    output cfg_reply_t        reply
);

    typedef struct packed {
        logic [SLOT_W-1:0]            slot;
        logic [SLOTS-1:0]             valid;
        logic [SLOTS-1:0][VC_W-1:0]   vcid;
        cfg_reply_t                   rep;
    } tbl_t;

    tbl_t              st_d, st_q;
    cfg_op_e           op;
    logic [SL_W-1:0]   free_cnt;
    logic [SL_W-1:0]   need;

    assign op = cfg_release ? OP_RELEASE : (cfg_reserve ? OP_RESERVE : OP_NONE);

    always_comb begin
        st_d      = st_q;
        st_d.rep  = '0;
        st_d.slot = (st_q.slot == SLOT_W'(SLOTS - 1)) ? '0 : st_q.slot + 1'b1;

        free_cnt = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (!st_q.valid[s]) free_cnt = free_cnt + 1'b1;
        end

        need = cfg_level;
        case (op)
            OP_RELEASE: begin
                for (int s = 0; s < SLOTS; s++) begin
                    if (st_q.valid[s] && st_q.vcid[s] == cfg_vc) st_d.valid[s] = 1'b0;
                end
                st_d.rep.done = 1'b1;
            end
            OP_RESERVE: begin
                if (cfg_level != '0 && cfg_level <= free_cnt) begin
                    for (int s = 0; s < SLOTS; s++) begin
                        if (!st_q.valid[s] && need != '0) begin
                            st_d.valid[s] = 1'b1;
                            st_d.vcid[s]  = cfg_vc;
                            need          = need - 1'b1;
                        end
                    end
                    st_d.rep.done = 1'b1;
                end else begin
                    st_d.rep.err = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (genvar v = 0; v < NUM_VC; v++) begin : g_bound
            logic [SLOTS-1:0] hit;
            for (genvar s = 0; s < SLOTS; s++) begin : g_slot
                assign hit[s] = st_q.valid[s] && (st_q.vcid[s] == VC_W'(v));
            end
            assign bound_mask[v] = |hit;
        end
    endgenerate

    assign cur_slot    = st_q.slot;
    assign owner_valid = st_q.valid[st_q.slot];
    assign owner_vc    = st_q.vcid[st_q.slot];
    assign reply       = st_q.rep;

endmodule

// File: rtl/tsls_credit_bank.sv
module tsls_credit_bank #(
    parameter int NUM_VC = 4,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_VC-1:0] send,
    input  logic [NUM_VC-1:0] ret,
    output logic [NUM_VC-1:0] has_credit
);

    typedef logic [NUM_VC-1:0][CNT_W-1:0] cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        for (int v = 0; v < NUM_VC; v++) begin
            case ({send[v], ret[v]})
                2'b10:   cnt_d[v] = cnt_q[v] - 1'b1;
                2'b01:   cnt_d[v] = cnt_q[v] + 1'b1;
                default: cnt_d[v] = cnt_q[v];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_VC; v++) cnt_q[v] <= CNT_W'(DEPTH);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    generate
        for (genvar v = 0; v < NUM_VC; v++) begin : g_flag
            assign has_credit[v] = (cnt_q[v] != '0);
        end
    endgenerate

endmodule

// File: rtl/tsls_rr_arb.sv
module tsls_rr_arb #(
    parameter int NUM_VC = 4,
    parameter int VC_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_VC-1:0] req,
    input  logic              adv,
    output logic [NUM_VC-1:0] gnt,
    output logic              gnt_any,
    output logic [VC_W-1:0]   gnt_idx
);

    logic [VC_W-1:0] ptr_d, ptr_q;

    always_comb begin
        gnt     = '0;
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int i = 0; i < NUM_VC; i++) begin
            int k;
            k = int'(ptr_q) + i;
            if (k >= NUM_VC) k = k - NUM_VC;
            if (!gnt_any && req[k]) begin
                gnt_any = 1'b1;
                gnt[k]  = 1'b1;
                gnt_idx = VC_W'(k);
            end
        end
        ptr_d = ptr_q;
        if (adv && gnt_any) begin
            ptr_d = (gnt_idx == VC_W'(NUM_VC - 1)) ? '0 : gnt_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

endmodule

// File: rtl/tslot_link_sched.sv
module tslot_link_sched
    import tsls_pkg::*;
#(
    parameter  int NUM_VC       = 4,
    parameter  int FLIT_W       = 32,
    parameter  int SLOTS        = 8,
    parameter  int CREDIT_DEPTH = 4,
    localparam int VC_W         = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
    localparam int SL_W         = $clog2(SLOTS + 1),
    localparam int SLOT_W       = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W        = $clog2(CREDIT_DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_VC-1:0]        vc_flit_valid,
    input  logic [NUM_VC*FLIT_W-1:0] vc_flit_data,
    output logic [NUM_VC-1:0]        vc_pop,
    input  logic [NUM_VC-1:0]        credit_return,
    input  logic                     cfg_reserve,
    input  logic                     cfg_release,
    input  logic [VC_W-1:0]          cfg_vc,
    input  logic [SL_W-1:0]          cfg_level,
    output logic                     cfg_done,
    output logic                     cfg_error,
    output logic                     link_valid,
    output logic [VC_W-1:0]          link_vc,
    output logic [FLIT_W-1:0]        link_data
);

    typedef struct packed {
        logic              valid;
        logic [VC_W-1:0]   vc;
        logic [FLIT_W-1:0] data;
    } link_t;

    logic [SLOT_W-1:0] cur_slot;
    logic              owner_valid;
    logic [VC_W-1:0]   owner_vc;
    logic [NUM_VC-1:0] bound_mask;
    cfg_reply_t        reply;
    logic [NUM_VC-1:0] has_credit;
    logic [NUM_VC-1:0] elig;
    logic [NUM_VC-1:0] be_gnt;
    logic              be_any;
    logic [VC_W-1:0]   be_idx;
    logic              gs_hit;
    logic [NUM_VC-1:0] grant;
    logic [VC_W-1:0]   grant_idx;
    link_t             link_d, link_q;

    tsls_slot_table #(
        .NUM_VC (NUM_VC),
        .SLOTS  (SLOTS),
        .VC_W   (VC_W),
        .SL_W   (SL_W),
        .SLOT_W (SLOT_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_reserve (cfg_reserve),
        .cfg_release (cfg_release),
        .cfg_vc      (cfg_vc),
        .cfg_level   (cfg_level),
        .cur_slot    (cur_slot),
        .owner_valid (owner_valid),
        .owner_vc    (owner_vc),
        .bound_mask  (bound_mask),
        .reply       (reply)
    );

    tsls_credit_bank #(
        .NUM_VC (NUM_VC),
        .DEPTH  (CREDIT_DEPTH),
        .CNT_W  (CNT_W)
    ) u_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .send       (grant),
        .ret        (credit_return),
        .has_credit (has_credit)
    );

    assign elig   = vc_flit_valid & has_credit;
    assign gs_hit = owner_valid && elig[owner_vc];

    tsls_rr_arb #(
        .NUM_VC (NUM_VC),
        .VC_W   (VC_W)
    ) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (elig & ~bound_mask),
        .adv     (!gs_hit),
        .gnt     (be_gnt),
        .gnt_any (be_any),
        .gnt_idx (be_idx)
    );

    always_comb begin
        grant     = '0;
        grant_idx = be_idx;
        if (gs_hit) begin
            grant[owner_vc] = 1'b1;
            grant_idx       = owner_vc;
        end else if (be_any) begin
            grant = be_gnt;
        end

        link_d       = '0;
        link_d.valid = |grant;
        link_d.vc    = grant_idx;
        for (int v = 0; v < NUM_VC; v++) begin
            if (grant[v]) link_d.data = vc_flit_data[v*FLIT_W +: FLIT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) link_q <= '0;
        else        link_q <= link_d;
    end

    assign vc_pop     = grant;
    assign link_valid = link_q.valid;
    assign link_vc    = link_q.vc;
    assign link_data  = link_q.data;
    assign cfg_done   = reply.done;
    assign cfg_error  = reply.err;

endmodule

// File: rtl/tsls_checker.sv
module tsls_checker #(
    parameter  int NUM_VC       = 4,
    parameter  int SLOTS        = 8,
    parameter  int CREDIT_DEPTH = 4,
    localparam int SLOT_W       = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_VC-1:0] vc_flit_valid,
    input logic [NUM_VC-1:0] vc_pop,
    input logic [NUM_VC-1:0] credit_return,
    input logic              cfg_reserve,
    input logic              cfg_release,
    input logic              cfg_done,
    input logic              cfg_error,
    input logic              link_valid,
    input logic [SLOT_W-1:0] cur_slot
);

    AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vc_pop)); // R2
    AST_POP_NEEDS_FLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (vc_pop & ~vc_flit_valid) == '0); // R2
    AST_POP_THEN_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (|vc_pop) |=> link_valid); // R2
    AST_IDLE_THEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(|vc_pop) |=> !link_valid); // R2
    AST_REPLY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_done && cfg_error)); // R8
    AST_REQ_GETS_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_reserve || cfg_release) |=> (cfg_done || cfg_error)); // R7
    AST_NO_SPURIOUS_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_reserve || cfg_release) |=> !(cfg_done || cfg_error)); // R7
    AST_RELEASE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_release |=> cfg_done); // R9
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_slot == SLOT_W'(SLOTS - 1)) |=> (cur_slot == '0)); // R10
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_slot != SLOT_W'(SLOTS - 1)) |=> (cur_slot == $past(cur_slot) + 1'b1)); // R10

    // independent credit tally built only from port activity
    int tally [NUM_VC];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_VC; v++) tally[v] <= CREDIT_DEPTH;
        end else begin
            for (int v = 0; v < NUM_VC; v++) begin
                tally[v] <= tally[v] - int'(vc_pop[v]) + int'(credit_return[v]);
            end
        end
    end

    generate
        for (genvar v = 0; v < NUM_VC; v++) begin : g_cred
            AST_NO_SEND_DRY: assert property (@(posedge clk) disable iff (!rst_n)
                (tally[v] == 0) |-> !vc_pop[v]); // R3
            AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
                (tally[v] == CREDIT_DEPTH) |-> !(credit_return[v] && !vc_pop[v])); // R3
        end
    endgenerate

endmodule

bind tslot_link_sched tsls_checker #(
    .NUM_VC       (NUM_VC),
    .SLOTS        (SLOTS),
    .CREDIT_DEPTH (CREDIT_DEPTH)
) u_tsls_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .vc_flit_valid (vc_flit_valid),
    .vc_pop        (vc_pop),
    .credit_return (credit_return),
    .cfg_reserve   (cfg_reserve),
    .cfg_release   (cfg_release),
    .cfg_done      (cfg_done),
    .cfg_error     (cfg_error),
    .link_valid    (link_valid),
    .cur_slot      (cur_slot)
);

// File: tb/tslot_link_sched_bench.sv
module tslot_link_sched_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV  = 4;
    localparam int FW  = 32;
    localparam int NS  = 8;
    localparam int DEP = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NV-1:0]    vc_flit_valid;
    logic [NV*FW-1:0] vc_flit_data;
    logic [NV-1:0]    vc_pop;
    logic [NV-1:0]    credit_return;
    logic             cfg_reserve, cfg_release;
    logic [1:0]       cfg_vc;
    logic [3:0]       cfg_level;
    logic             cfg_done, cfg_error;
    logic             link_valid;
    logic [1:0]       link_vc;
    logic [FW-1:0]    link_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    tslot_link_sched u_tslot_link_sched (
        .clk(clk), .rst_n(rst_n),
        .vc_flit_valid(vc_flit_valid), .vc_flit_data(vc_flit_data), .vc_pop(vc_pop),
        .credit_return(credit_return),
        .cfg_reserve(cfg_reserve), .cfg_release(cfg_release),
        .cfg_vc(cfg_vc), .cfg_level(cfg_level),
        .cfg_done(cfg_done), .cfg_error(cfg_error),
        .link_valid(link_valid), .link_vc(link_vc), .link_data(link_data)
    );

    // behavioural reference state
    bit          m_own [NS];
    int          m_owner [NS];
    int          m_slot, m_rr, seq;
    int          m_cred [NV];
    logic [FW-1:0] fq [NV][$];
    bit          exp_valid, exp_done, exp_err;
    int          exp_vc;
    logic [FW-1:0] exp_data;
    int          vectors = 0, miscompares = 0;
    bit          finished = 1'b0;

    function automatic bit is_bound(int v);
        for (int s = 0; s < NS; s++) if (m_own[s] && m_owner[s] == v) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int pick(output bit gs);
        int o;
        gs = 1'b0;
        o = m_owner[m_slot];
        if (m_own[m_slot] && fq[o].size() > 0 && m_cred[o] > 0) begin
            gs = 1'b1;
            return o;
        end
        for (int i = 0; i < NV; i++) begin
            int v;
            v = (m_rr + i) % NV;
            if (!is_bound(v) && fq[v].size() > 0 && m_cred[v] > 0) return v;
        end
        return -1;
    endfunction

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(int v, int n);
        for (int i = 0; i < n; i++) begin
            fq[v].push_back({8'(v), 24'(seq)});
            seq++;
        end
    endtask

    // entered at a falling edge; drives, checks pop, takes one rising edge, checks registered outputs
    task automatic step(string tag, logic [NV-1:0] ret = '0, bit res = 1'b0, bit rel = 1'b0,
                        int cvc = 0, int lvl = 0);
        int g;
        bit gs;
        logic [NV-1:0] ret_app;
        for (int v = 0; v < NV; v++) begin
            vc_flit_valid[v] = (fq[v].size() > 0);
            vc_flit_data[v*FW +: FW] = (fq[v].size() > 0) ? fq[v][0] : '0;
            ret_app[v] = ret[v] && (m_cred[v] < DEP);
        end
        credit_return = ret_app;
        cfg_reserve = res;
        cfg_release = rel;
        cfg_vc = 2'(cvc);
        cfg_level = 4'(lvl);
        #1;
        g = pick(gs);
        check(vc_pop === ((g >= 0) ? 4'(1 << g) : 4'h0), tag, "R2 vc_pop", 64'(vc_pop),
              (g >= 0) ? 64'(1 << g) : 64'h0);
        @(posedge clk);
        exp_valid = (g >= 0);
        if (g >= 0) begin
            exp_vc = g;
            exp_data = fq[g].pop_front();
            m_cred[g]--;
            if (!gs) m_rr = (g + 1) % NV;
        end
        for (int v = 0; v < NV; v++) if (ret_app[v]) m_cred[v]++;
        exp_done = 1'b0;
        exp_err = 1'b0;
        if (rel) begin
            for (int s = 0; s < NS; s++) if (m_own[s] && m_owner[s] == cvc) m_own[s] = 1'b0;
            exp_done = 1'b1;
        end else if (res) begin
            int free, need;
            free = 0;
            for (int s = 0; s < NS; s++) if (!m_own[s]) free++;
            if (lvl >= 1 && lvl <= free) begin
                need = lvl;
                for (int s = 0; s < NS; s++) begin
                    if (!m_own[s] && need > 0) begin
                        m_own[s] = 1'b1;
                        m_owner[s] = cvc;
                        need--;
                    end
                end
                exp_done = 1'b1;
            end else begin
                exp_err = 1'b1;
            end
        end
        m_slot = (m_slot + 1) % NS;
        @(negedge clk);
        check(link_valid === exp_valid, tag, "link_valid", 64'(link_valid), 64'(exp_valid));
        if (exp_valid) begin
            check(link_vc === 2'(exp_vc), tag, "R2 link_vc", 64'(link_vc), 64'(exp_vc));
            check(link_data === exp_data, tag, "R2 link_data", 64'(link_data), 64'(exp_data));
        end
        check(cfg_done === exp_done, tag, "cfg_done", 64'(cfg_done), 64'(exp_done));
        check(cfg_error === exp_err, tag, "cfg_error", 64'(cfg_error), 64'(exp_err));
    endtask

    task automatic drain(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 4'hF);
    endtask

    initial begin
        rst_n = 1'b0;
        vc_flit_valid = '0;
        vc_flit_data = '0;
        credit_return = '0;
        cfg_reserve = 1'b0;
        cfg_release = 1'b0;
        cfg_vc = '0;
        cfg_level = '0;
        seq = 1;
        m_slot = 0;
        m_rr = 0;
        for (int s = 0; s < NS; s++) begin m_own[s] = 1'b0; m_owner[s] = 0; end
        for (int v = 0; v < NV; v++) m_cred[v] = DEP;
        exp_valid = 1'b0; exp_done = 1'b0; exp_err = 1'b0; exp_vc = 0; exp_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(link_valid === 1'b0, "R1", "reset link_valid", 64'(link_valid), 64'h0);
        check(cfg_done === 1'b0, "R1", "reset cfg_done", 64'(cfg_done), 64'h0);
        check(cfg_error === 1'b0, "R1", "reset cfg_error", 64'(cfg_error), 64'h0);
        check(vc_pop === 4'h0, "R1", "reset vc_pop", 64'(vc_pop), 64'h0);
        rst_n = 1'b1;

        // R1: full credit after reset, four sends on one channel without returns
        push(3, 4);
        repeat (6) step("R1");
        // R3: exhaustion on a second channel, then send and return in the same cycle
        push(2, 6);
        repeat (8) step("R3");
        repeat (3) step("R3", 4'b0100);
        push(2, 3);
        repeat (4) step("R3", 4'b0100);
        drain("R3", 10);

        // R6: round robin among unreserved channels
        for (int v = 0; v < NV; v++) push(v, 3);
        repeat (14) step("R6", 4'hF);
        push(1, 2); push(3, 2);
        repeat (6) step("R6", 4'hF);
        drain("R6", 6);

        // R7: reserve channel 1 at level 3 -> slots 0..2
        step("R7", 4'hF, 1'b1, 1'b0, 1, 3);
        push(1, 8); push(0, 8); push(2, 4);
        // R5 and R4: reserved channel only in its own slots, owner wins there
        repeat (24) step("R5", 4'hF);
        push(1, 4);
        repeat (12) step("R4", 4'hF);

        // R8: refusals leave the table intact
        step("R8", 4'hF, 1'b1, 1'b0, 2, 6);
        step("R8", 4'hF, 1'b1, 1'b0, 2, 0);
        step("R7", 4'hF, 1'b1, 1'b0, 2, 5);
        step("R8", 4'hF, 1'b1, 1'b0, 3, 1);
        for (int v = 0; v < NV; v++) push(v, 5);
        repeat (24) step("R8", 4'hF);

        // R9: release beats a simultaneous reserve
        step("R9", 4'hF, 1'b1, 1'b1, 1, 1);
        step("R9", 4'hF, 1'b1, 1'b0, 3, 2);
        for (int v = 0; v < NV; v++) push(v, 4);
        repeat (20) step("R9", 4'hF);
        step("R9", 4'hF, 1'b0, 1'b1, 2);
        step("R9", 4'hF, 1'b0, 1'b1, 3);
        step("R9", 4'hF, 1'b0, 1'b1, 0);

        // R10: single-slot owner sends once per table period
        step("R10", 4'hF, 1'b1, 1'b0, 0, 1);
        push(0, 6);
        repeat (40) step("R10", 4'hF);
        step("R10", 4'hF, 1'b0, 1'b1, 0);

        // R4: mixed traffic with configuration changes
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 15);
            if ($urandom_range(0, 2) == 0) push($urandom_range(0, NV - 1), $urandom_range(1, 3));
            if (r == 0)
                step("R4", 4'($urandom_range(0, 15)), 1'b1, 1'b0,
                     $urandom_range(0, NV - 1), $urandom_range(0, 4));
            else if (r == 1)
                step("R4", 4'($urandom_range(0, 15)), 1'b0, 1'b1, $urandom_range(0, NV - 1));
            else
                step("R4", 4'($urandom_range(0, 15)));
        end
        drain("R4", 60);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule